// File: doc/BRIEF.md
# Rotate, Mask and Shift Unit

This is a purely combinational datapath block for a 64-bit fixed-point execution stage. It rotates a source operand left, applies a contiguous or wrapping bit mask, and merges the masked bits with zero, with the previous destination value (insert forms), or with copies of the sign bit (arithmetic right shifts). A single rotator serves every operation. A right shift by `n` is carried out as a left rotate by `-n mod 64` followed by a mask. It also produces the carry that an arithmetic right shift reports.

The caller selects one of five operations and sets three controls. Word mode selects the 32-bit forms. Arithmetic mode selects sign filling on right shifts. Insert mode keeps the old destination bits outside the mask. Mask boundaries use big-endian bit numbering, so position 0 is the most significant bit. For word-form rotates the caller supplies the positions already offset into the low word (32 to 63). The result is valid in the same cycle as the operands.

Top module: `rms_unit`

## Requirements
- R1: Operation code 0 (rotate, mask both sides) returns the source rotated left by `shamt[5:0]`, ANDed with a mask. The mask has ones at big-endian positions `mask_beg` through `mask_end` inclusive (position p is result bit 63-p). When `mask_beg > mask_end` the mask wraps: ones from `mask_beg` to 63 and from 0 to `mask_end`.
- R2: Operation code 1 (rotate, clear high side) uses the mask from `mask_beg` through 63 and ignores `mask_end`.
- R3: Operation code 2 (rotate, clear low side) uses the mask from 0 through `mask_end` and ignores `mask_beg`.
- R4: With `word_mode` = 1, the rotate operations (codes 0 to 2) rotate the 64-bit value formed by two copies of `src_val[31:0]`. A full-width mask then gives equal upper and lower halves.
- R5: With `ins_en` = 1, rotate codes 0 to 2 take every result bit outside the mask from `dst_val`. `ins_en` has no effect on codes 3 and 4.
- R6: Operation code 3 (shift left) in doubleword mode shifts by `shamt[6:0]` and gives zero when `shamt[6]` = 1. In word mode it shifts `src_val[31:0]` by `shamt[4:0]`, gives zero when `shamt[5]` = 1, and always clears `result[63:32]`.
- R7: Operation code 4 with `arith_en` = 0 is a logical right shift. Doubleword mode shifts by `shamt[6:0]` and gives zero when `shamt[6]` = 1. Word mode shifts `src_val[31:0]` by `shamt[4:0]`, gives zero when `shamt[5]` = 1, and always clears `result[63:32]`.
- R8: Operation code 4 with `arith_en` = 1 fills every vacated bit with the sign bit. The sign bit is `src_val[63]` in doubleword mode and `src_val[31]` in word mode, and in word mode the whole upper half is filled. An overflowing amount (`shamt[6]` doubleword, `shamt[5]` word) gives 64 copies of the sign bit.
- R9: `carry_out` is 1 only for code 4 with `arith_en` = 1 when the sign bit is 1 and at least one 1 bit of the operand (low 32 bits in word mode) was shifted out. With an overflowing amount, every operand bit counts as shifted out. In all other cases `carry_out` is 0.
- R10: `arith_en` has no effect on operation codes 0 to 3.
- R11: Operation codes 5 to 7 give a zero result and a zero carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 64 | Operand to rotate or shift |
| dst_val | input | 64 | Previous destination value, used by insert forms |
| shamt | input | 7 | Rotate or shift amount; bit 6 and bit 5 flag overflow for shifts |
| mask_beg | input | 6 | First mask position, big-endian numbering |
| mask_end | input | 6 | Last mask position, big-endian numbering |
| op_sel | input | 3 | Operation code (0 to 4 defined) |
| word_mode | input | 1 | Selects 32-bit forms |
| arith_en | input | 1 | Sign-filling right shift |
| ins_en | input | 1 | Keep destination bits outside the mask on rotates |
| result | output | 64 | Rotated, masked and merged value |
| carry_out | output | 1 | Carry of an arithmetic right shift |

## Verification
No register lies between any input and `result` or `carry_out`, so both outputs are due in the same cycle as the operands that produce them. The bench changes operands just after a rising clock edge and compares both outputs with its behavioural model at the following falling edge, half a period later, once every input has settled. Each clock applies one vector. Directed vectors cover zero amounts, the amounts 31, 32, 63, 64 and 127, wrapping masks and the sign cases, and seeded random vectors follow them.

// File: rtl/rms_pkg.sv
// Package: shared operation codes for the rotate/mask/shift unit.
// Assumes a three-bit operation field; codes above OP_SHR are unused.
package rms_pkg;

    localparam int RMS_OP_W = 3;

    typedef enum logic [RMS_OP_W-1:0] {
        OP_ROT_MASK  = 3'd0,   // rotate, clear outside [beg, end]
        OP_ROT_CLRHI = 3'd1,   // rotate, clear high-order side only
        OP_ROT_CLRLO = 3'd2,   // rotate, clear low-order side only
        OP_SHL       = 3'd3,   // shift left
        OP_SHR       = 3'd4    // shift right, logical or arithmetic
    } rms_op_e;

endpackage

// File: rtl/rms_rotator.sv
// Module: rms_rotator
// Rotates a word left by a binary amount using cascaded 4:1 selector
// stages. Stage k moves the value by digit*4**k, so ceil(log2(W)/2)
// stages cover every amount from 0 to W-1.
// Assumes DATA_W is a power of two.
module rms_rotator #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         din,
    input  logic [$clog2(DATA_W)-1:0] amt,
    output logic [DATA_W-1:0]         dout
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int NSTG  = (SH_W + 1) / 2;
    localparam int AMT_W = 2 * NSTG;

    // Rotate left by a constant distance.
    function automatic logic [DATA_W-1:0] rot_const(input logic [DATA_W-1:0] x,
                                                    input int s);
        int d;
        d = s % DATA_W;
        if (d == 0) return x;
        return (x << d) | (x >> (DATA_W - d));
    endfunction

    logic [AMT_W-1:0]  amt_p;
    logic [DATA_W-1:0] stg [NSTG+1];

    assign amt_p  = AMT_W'(amt);
    assign stg[0] = din;

    genvar k;
    generate
        for (k = 0; k < NSTG; k++) begin : g_stage
            localparam int STEP = 4 ** k;
            logic [1:0]        dig;
            logic [DATA_W-1:0] sel_q;
            assign dig = amt_p[2*k +: 2];
            // Pick one of four rotated copies for this stage.
            always_comb begin
                case (dig)
                    2'd0:    sel_q = stg[k];
                    2'd1:    sel_q = rot_const(stg[k], STEP);
                    2'd2:    sel_q = rot_const(stg[k], 2 * STEP);
                    default: sel_q = rot_const(stg[k], 3 * STEP);
                endcase
            end
            assign stg[k+1] = sel_q;
        end
    endgenerate

    assign dout = stg[NSTG];

endmodule

// File: rtl/rms_maskgen.sv
// Module: rms_maskgen
// Builds a one-sided mask in big-endian numbering (position p is bit
// DATA_W-1-p). With CLEAR_HIGH=1 the mask holds ones from pos to the
// last position; otherwise it holds ones from position 0 through pos.
module rms_maskgen #(
    parameter int DATA_W     = 64,
    parameter bit CLEAR_HIGH = 1'b1
) (
    input  logic [$clog2(DATA_W)-1:0] pos,
    output logic [DATA_W-1:0]         mask
);
    localparam int SH_W = $clog2(DATA_W);

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [SH_W-1:0] BEPOS = SH_W'(DATA_W - 1 - i);
            if (CLEAR_HIGH) begin : g_hi
                assign mask[i] = (BEPOS >= pos);
            end else begin : g_lo
                assign mask[i] = (BEPOS <= pos);
            end
        end
    endgenerate

endmodule

// File: rtl/rms_ctrl.sv
// Module: rms_ctrl
// Turns the operation code, mode bits and amount into a rotate amount,
// mask boundaries and merge controls for the datapath.
// Assumes DATA_W is a power of two of at least 4.
module rms_ctrl
    import rms_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [RMS_OP_W-1:0]       op_sel,
    input  logic                      word_mode,
    input  logic                      arith_en,
    input  logic                      ins_en,
    input  logic [$clog2(DATA_W):0]   shamt,
    input  logic [$clog2(DATA_W)-1:0] mask_beg,
    input  logic [$clog2(DATA_W)-1:0] mask_end,
    input  logic                      src_msb,
    input  logic                      src_wmsb,
    output logic [$clog2(DATA_W)-1:0] rot_amt,
    output logic [$clog2(DATA_W)-1:0] beg_pos,
    output logic [$clog2(DATA_W)-1:0] end_pos,
    output logic                      mask_none,
    output logic                      fill_en,
    output logic                      ins_sel,
    output logic                      carry_en,
    output logic                      sign_bit
);
    localparam int SH_W = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [SH_W-1:0] HALF_POS = SH_W'(HALF_W);
    localparam logic [SH_W-1:0] LAST_POS = SH_W'(DATA_W - 1);

    logic            ovf;
    logic [SH_W-1:0] n_eff;

    // Overflow flag and effective shift count for the selected width.
    always_comb begin
        ovf      = word_mode ? shamt[SH_W-1] : shamt[SH_W];
        n_eff    = word_mode ? {1'b0, shamt[SH_W-2:0]} : shamt[SH_W-1:0];
        sign_bit = word_mode ? src_wmsb : src_msb;
    end

    // Decode the operation into mask bounds and merge controls.
    always_comb begin
        rot_amt   = shamt[SH_W-1:0];
        beg_pos   = mask_beg;
        end_pos   = mask_end;
        mask_none = 1'b0;
        fill_en   = 1'b0;
        ins_sel   = 1'b0;
        carry_en  = 1'b0;
        case (op_sel)
            OP_ROT_MASK: begin
                ins_sel = ins_en;
            end
            OP_ROT_CLRHI: begin
                end_pos = LAST_POS;
                ins_sel = ins_en;
            end
            OP_ROT_CLRLO: begin
                beg_pos = '0;
                ins_sel = ins_en;
            end
            OP_SHL: begin
                beg_pos   = word_mode ? HALF_POS : '0;
                end_pos   = LAST_POS - n_eff;
                mask_none = ovf;
            end
            OP_SHR: begin
                rot_amt   = SH_W'(0) - shamt[SH_W-1:0];
                beg_pos   = (word_mode ? HALF_POS : '0) + n_eff;
                end_pos   = LAST_POS;
                mask_none = ovf;
                fill_en   = arith_en & sign_bit;
                carry_en  = arith_en;
            end
            default: begin
                mask_none = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rms_outsel.sv
// Module: rms_outsel
// Combines the two one-sided masks, applies the mask to the rotated
// value, merges zeros, destination bits or sign copies, and forms the
// arithmetic-shift carry.
module rms_outsel #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         rot_val,
    input  logic [DATA_W-1:0]         dst_val,
    input  logic [DATA_W-1:0]         hi_mask,
    input  logic [DATA_W-1:0]         lo_mask,
    input  logic [$clog2(DATA_W)-1:0] beg_pos,
    input  logic [$clog2(DATA_W)-1:0] end_pos,
    input  logic                      mask_none,
    input  logic                      fill_en,
    input  logic                      ins_sel,
    input  logic                      carry_en,
    input  logic                      sign_bit,
    input  logic                      word_mode,
    output logic [DATA_W-1:0]         result,
    output logic                      carry_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] m_eff;
    logic [DATA_W-1:0] out_win;

    // Join the two masks: AND when contiguous, OR when wrapping.
    always_comb begin
        if (mask_none)
            m_eff = '0;
        else if (beg_pos <= end_pos)
            m_eff = hi_mask & lo_mask;
        else
            m_eff = hi_mask | lo_mask;
    end

    // Merge masked rotate output with destination or sign fill.
    always_comb begin
        result = rot_val & m_eff;
        if (ins_sel)
            result = result | (dst_val & ~m_eff);
        if (fill_en)
            result = result | ~m_eff;
    end

    // Carry: any operand bit rotated outside the kept field.
    always_comb begin
        out_win   = word_mode ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
        carry_out = carry_en & sign_bit & (|(rot_val & ~m_eff & out_win));
    end

endmodule

// File: rtl/rms_unit.sv
// Module: rms_unit (top)
// Combinational rotate/mask/shift unit. One rotator feeds two mask
// generators and an output merge stage. Word mode replicates the low
// half of the source before rotating. No clock or reset: outputs follow
// inputs in the same cycle.
module rms_unit
    import rms_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         src_val,
    input  logic [DATA_W-1:0]         dst_val,
    input  logic [$clog2(DATA_W):0]   shamt,
    input  logic [$clog2(DATA_W)-1:0] mask_beg,
    input  logic [$clog2(DATA_W)-1:0] mask_end,
    input  logic [RMS_OP_W-1:0]       op_sel,
    input  logic                      word_mode,
    input  logic                      arith_en,
    input  logic                      ins_en,
    output logic [DATA_W-1:0]         result,
    output logic                      carry_out
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] rot_in;
    logic [DATA_W-1:0] rot_val;
    logic [DATA_W-1:0] hi_mask;
    logic [DATA_W-1:0] lo_mask;
    logic [SH_W-1:0]   rot_amt;
    logic [SH_W-1:0]   beg_pos;
    logic [SH_W-1:0]   end_pos;
    logic              mask_none;
    logic              fill_en;
    logic              ins_sel;
    logic              carry_en;
    logic              sign_bit;

    // Replicate the low half in word mode so both halves rotate alike.
    always_comb begin
        rot_in = word_mode ? {2{src_val[HALF_W-1:0]}} : src_val;
    end

    rms_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .op_sel    (op_sel),
        .word_mode (word_mode),
        .arith_en  (arith_en),
        .ins_en    (ins_en),
        .shamt     (shamt),
        .mask_beg  (mask_beg),
        .mask_end  (mask_end),
        .src_msb   (src_val[DATA_W-1]),
        .src_wmsb  (src_val[HALF_W-1]),
        .rot_amt   (rot_amt),
        .beg_pos   (beg_pos),
        .end_pos   (end_pos),
        .mask_none (mask_none),
        .fill_en   (fill_en),
        .ins_sel   (ins_sel),
        .carry_en  (carry_en),
        .sign_bit  (sign_bit)
    );

    rms_rotator #(.DATA_W(DATA_W)) rot_i (
        .din  (rot_in),
        .amt  (rot_amt),
        .dout (rot_val)
    );

    rms_maskgen #(.DATA_W(DATA_W), .CLEAR_HIGH(1'b1)) mask_hi_i (
        .pos  (beg_pos),
        .mask (hi_mask)
    );

    rms_maskgen #(.DATA_W(DATA_W), .CLEAR_HIGH(1'b0)) mask_lo_i (
        .pos  (end_pos),
        .mask (lo_mask)
    );

    rms_outsel #(.DATA_W(DATA_W)) out_i (
        .rot_val   (rot_val),
        .dst_val   (dst_val),
        .hi_mask   (hi_mask),
        .lo_mask   (lo_mask),
        .beg_pos   (beg_pos),
        .end_pos   (end_pos),
        .mask_none (mask_none),
        .fill_en   (fill_en),
        .ins_sel   (ins_sel),
        .carry_en  (carry_en),
        .sign_bit  (sign_bit),
        .word_mode (word_mode),
        .result    (result),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/rms_unit_chk.sv
// Module: rms_unit_chk
// Port-level checks for rms_unit. The block has no clock, so the checks
// are immediate assertions evaluated whenever an input or output moves.
module rms_unit_chk
    import rms_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic [DATA_W-1:0]         src_val,
    input logic [$clog2(DATA_W):0]   shamt,
    input logic [$clog2(DATA_W)-1:0] mask_beg,
    input logic [$clog2(DATA_W)-1:0] mask_end,
    input logic [RMS_OP_W-1:0]       op_sel,
    input logic                      word_mode,
    input logic                      arith_en,
    input logic                      ins_en,
    input logic [DATA_W-1:0]         result,
    input logic                      carry_out
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    logic sgn;
    logic ovf;

    // Evaluate output relations against the current operands.
    always_comb begin
        sgn = word_mode ? src_val[HALF_W-1] : src_val[DATA_W-1];
        ovf = word_mode ? shamt[SH_W-1] : shamt[SH_W];
        if (!(op_sel == OP_SHR && arith_en)) begin
            // R9
            carry_gate_chk: assert (carry_out == 1'b0);
        end
        if (!sgn) begin
            // R9
            pos_src_nocarry_chk: assert (carry_out == 1'b0);
        end
        if (op_sel == OP_SHL && ovf) begin
            // R6
            shl_ovf_zero_chk: assert (result == '0);
        end
        if (op_sel == OP_SHR && word_mode && !arith_en) begin
            // R7
            srw_upper_zero_chk: assert (result[DATA_W-1:HALF_W] == '0);
        end
        if (op_sel == OP_SHR && arith_en && ovf) begin
            // R8
            sra_ovf_fill_chk: assert (result == {DATA_W{sgn}});
        end
        if (op_sel == OP_ROT_MASK && word_mode && !ins_en &&
            mask_beg == '0 && mask_end == '1) begin
            // R4
            word_rot_halves_chk: assert (result[DATA_W-1:HALF_W] == result[HALF_W-1:0]);
        end
        if (op_sel == OP_ROT_MASK && !word_mode && !ins_en && shamt[SH_W-1:0] == '0 &&
            mask_beg == '0 && mask_end == '1) begin
            // R1
            rot_identity_chk: assert (result == src_val);
        end
        if (op_sel > OP_SHR) begin
            // R11
            unused_op_zero_chk: assert (result == '0 && carry_out == 1'b0);
        end
    end

endmodule

bind rms_unit rms_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .src_val   (src_val),
    .shamt     (shamt),
    .mask_beg  (mask_beg),
    .mask_end  (mask_end),
    .op_sel    (op_sel),
    .word_mode (word_mode),
    .arith_en  (arith_en),
    .ins_en    (ins_en),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/rms_unit_tb_top.sv
// Bench for rms_unit: a behavioural model computes each expected result
// from the requirements; one vector is applied per clock and compared
// at the falling edge.
module rms_unit_tb_top;

    logic        clk;
    logic        rst_n;
    logic [63:0] src_val;
    logic [63:0] dst_val;
    logic [6:0]  shamt;
    logic [5:0]  mask_beg;
    logic [5:0]  mask_end;
    logic [2:0]  op_sel;
    logic        word_mode;
    logic        arith_en;
    logic        ins_en;
    logic [63:0] result;
    logic        carry_out;

    int n_chk;
    int n_fail;
    bit done;

    rms_unit dut_i (
        .src_val   (src_val),
        .dst_val   (dst_val),
        .shamt     (shamt),
        .mask_beg  (mask_beg),
        .mask_end  (mask_end),
        .op_sel    (op_sel),
        .word_mode (word_mode),
        .arith_en  (arith_en),
        .ins_en    (ins_en),
        .result    (result),
        .carry_out (carry_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Behavioural model: {carry, result}.
    function automatic logic [64:0] model(input logic [63:0] s, input logic [63:0] d,
                                          input logic [6:0] a, input logic [5:0] b,
                                          input logic [5:0] e, input logic [2:0] op,
                                          input logic w, input logic ar, input logic ins);
        logic [63:0] x, r, m, res, sx, lowm;
        logic [31:0] v, t32;
        logic        c, sg;
        int n, bb, ee;
        c = 1'b0;
        res = '0;
        if (op <= 3'd2) begin
            x  = w ? {s[31:0], s[31:0]} : s;
            n  = int'(a[5:0]);
            r  = (n == 0) ? x : ((x << n) | (x >> (64 - n)));
            bb = (op == 3'd2) ? 0 : int'(b);
            ee = (op == 3'd1) ? 63 : int'(e);
            for (int p = 0; p < 64; p++)
                m[63-p] = (bb <= ee) ? (p >= bb && p <= ee) : (p >= bb || p <= ee);
            res = (r & m) | (ins ? (d & ~m) : 64'd0);
        end else if (op == 3'd3) begin
            if (w) begin
                n = int'(a[5:0]);
                t32 = s[31:0] << n;
                res = (n >= 32) ? 64'd0 : {32'd0, t32};
            end else begin
                n = int'(a);
                res = (n >= 64) ? 64'd0 : (s << n);
            end
        end else if (op == 3'd4) begin
            if (w) begin
                v  = s[31:0];
                n  = int'(a[5:0]);
                sg = ar & v[31];
                sx = sg ? {32'hFFFF_FFFF, v} : {32'd0, v};
                if (n >= 32) begin
                    res = sg ? '1 : 64'd0;
                    c   = sg & (|v);
                end else begin
                    res  = 64'($signed(sx) >>> n);
                    lowm = (64'd1 << n) - 64'd1;
                    c    = sg & (|({32'd0, v} & lowm));
                end
            end else begin
                n  = int'(a);
                sg = ar & s[63];
                if (n >= 64) begin
                    res = sg ? '1 : 64'd0;
                    c   = sg & (|s);
                end else begin
                    res  = ar ? 64'($signed(s) >>> n) : (s >> n);
                    lowm = (64'd1 << n) - 64'd1;
                    c    = sg & (|(s & lowm));
                end
            end
        end
        return {c, res};
    endfunction

    // Requirement tag for a vector's result check.
    function automatic string res_tag(input logic [2:0] op, input logic w,
                                      input logic ar, input logic ins);
        if (op > 3'd4) return "R11";
        if (op == 3'd4) return ar ? "R8" : "R7";
        if (ins) return "R5";
        if (ar) return "R10";
        if (op == 3'd3) return "R6";
        if (w) return "R4";
        if (op == 3'd1) return "R2";
        if (op == 3'd2) return "R3";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one vector after a rising edge, compare at the falling edge.
    task automatic apply(input logic [63:0] s, input logic [63:0] d, input logic [6:0] a,
                         input logic [5:0] b, input logic [5:0] e, input logic [2:0] op,
                         input logic w, input logic ar, input logic ins);
        logic [64:0] exp;
        @(posedge clk);
        src_val = s; dst_val = d; shamt = a; mask_beg = b; mask_end = e;
        op_sel = op; word_mode = w; arith_en = ar; ins_en = ins;
        @(negedge clk);
        exp = model(s, d, a, b, e, op, w, ar, ins);
        check(res_tag(op, w, ar, ins), result, exp[63:0]);
        check("R9", {63'd0, carry_out}, {63'd0, exp[64]});
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] ns, nd;
        n_chk = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0;
        src_val = '0; dst_val = '0; shamt = '0; mask_beg = '0; mask_end = '0;
        op_sel = '0; word_mode = 1'b0; arith_en = 1'b0; ins_en = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle inputs give a zero result and no carry
        check("R1", result, 64'd0);
        check("R9", {63'd0, carry_out}, 64'd0);

        // R1: known rotate by 8 with full mask
        apply(64'h0123_4567_89AB_CDEF, 64'd0, 7'd8, 6'd0, 6'd63, 3'd0, 1'b0, 1'b0, 1'b0);
        check("R1", result, 64'h2345_6789_ABCD_EF01);
        apply(64'hF0F0_0000_FFFF_1234, 64'd0, 7'd0, 6'd0, 6'd63, 3'd0, 1'b0, 1'b0, 1'b0);
        apply(64'hDEAD_BEEF_CAFE_F00D, 64'd0, 7'd13, 6'd50, 6'd10, 3'd0, 1'b0, 1'b0, 1'b0);
        apply(64'hDEAD_BEEF_CAFE_F00D, 64'd0, 7'd63, 6'd20, 6'd20, 3'd0, 1'b0, 1'b0, 1'b0);
        // R2 / R3
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd4, 6'd16, 6'd2, 3'd1, 1'b0, 1'b0, 1'b0);
        check("R2", result, 64'h0000_FFFF_FFFF_FFFF);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd4, 6'd40, 6'd7, 3'd2, 1'b0, 1'b0, 1'b0);
        check("R3", result, 64'hFF00_0000_0000_0000);
        // R4: word rotates
        apply(64'h1111_2222_8000_0001, 64'd0, 7'd1, 6'd0, 6'd63, 3'd0, 1'b1, 1'b0, 1'b0);
        check("R4", result, 64'h0000_0003_0000_0003);
        apply(64'h1111_2222_8765_4321, 64'd0, 7'd36, 6'd60, 6'd40, 3'd0, 1'b1, 1'b0, 1'b0);
        // R5: insert and no effect on shifts
        apply(64'h0000_0000_0000_00AB, 64'hFFFF_FFFF_FFFF_FFFF, 7'd8, 6'd48, 6'd55, 3'd0, 1'b0, 1'b0, 1'b1);
        check("R5", result, 64'hFFFF_FFFF_FFFF_ABFF);
        apply(64'h0000_0000_0000_00F1, 64'h5555_5555_5555_5555, 7'd3, 6'd0, 6'd0, 3'd3, 1'b0, 1'b0, 1'b1);
        apply(64'h8000_0000_0000_00F1, 64'h5555_5555_5555_5555, 7'd3, 6'd0, 6'd0, 3'd4, 1'b0, 1'b1, 1'b1);
        // R6: shift left, boundaries
        apply(64'h8000_0000_0000_0001, 64'd0, 7'd63, 6'd0, 6'd0, 3'd3, 1'b0, 1'b0, 1'b0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd64, 6'd0, 6'd0, 3'd3, 1'b0, 1'b0, 1'b0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd31, 6'd0, 6'd0, 3'd3, 1'b1, 1'b0, 1'b0);
        check("R6", result, 64'h0000_0000_8000_0000);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd32, 6'd0, 6'd0, 3'd3, 1'b1, 1'b0, 1'b0);
        // R7: logical right
        apply(64'hF000_0000_0000_000F, 64'd0, 7'd4, 6'd0, 6'd0, 3'd4, 1'b0, 1'b0, 1'b0);
        check("R7", result, 64'h0F00_0000_0000_0000);
        apply(64'hFFFF_FFFF_8000_0000, 64'd0, 7'd31, 6'd0, 6'd0, 3'd4, 1'b1, 1'b0, 1'b0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd127, 6'd0, 6'd0, 3'd4, 1'b0, 1'b0, 1'b0);
        // R8 / R9: arithmetic right and carry
        apply(64'h8000_0000_0000_0001, 64'd0, 7'd1, 6'd0, 6'd0, 3'd4, 1'b0, 1'b1, 1'b0);
        check("R8", result, 64'hC000_0000_0000_0000);
        check("R9", {63'd0, carry_out}, 64'd1);
        apply(64'h8000_0000_0000_0010, 64'd0, 7'd4, 6'd0, 6'd0, 3'd4, 1'b0, 1'b1, 1'b0);
        apply(64'h7000_0000_0000_00FF, 64'd0, 7'd8, 6'd0, 6'd0, 3'd4, 1'b0, 1'b1, 1'b0);
        apply(64'h8000_0000_0000_0000, 64'd0, 7'd64, 6'd0, 6'd0, 3'd4, 1'b0, 1'b1, 1'b0);
        apply(64'h0000_0000_8000_0003, 64'd0, 7'd2, 6'd0, 6'd0, 3'd4, 1'b1, 1'b1, 1'b0);
        check("R8", result, 64'hFFFF_FFFF_E000_0000);
        apply(64'h0000_0000_8000_0000, 64'd0, 7'd32, 6'd0, 6'd0, 3'd4, 1'b1, 1'b1, 1'b0);
        apply(64'h0000_0000_8000_0000, 64'd0, 7'd0, 6'd0, 6'd0, 3'd4, 1'b1, 1'b1, 1'b0);
        // R10: arith ignored on rotates and left shifts
        apply(64'h8123_4567_89AB_CDEF, 64'd0, 7'd5, 6'd3, 6'd60, 3'd0, 1'b0, 1'b1, 1'b0);
        apply(64'h8123_4567_89AB_CDEF, 64'd0, 7'd5, 6'd0, 6'd0, 3'd3, 1'b0, 1'b1, 1'b0);
        // R11: unused codes
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd3, 6'd0, 6'd63, 3'd5, 1'b0, 1'b1, 1'b1);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd0, 6'd0, 6'd63, 3'd7, 1'b1, 1'b0, 1'b0);

        // Seeded random vectors over all controls.
        void'($urandom(32'd12345));
        for (int i = 0; i < 1500; i++) begin
            logic [6:0] a;
            ns = {$urandom, $urandom};
            nd = {$urandom, $urandom};
            a  = 7'($urandom);
            if (i % 4 == 0) a = {1'b0, a[5:0]};
            apply(ns, nd, a, 6'($urandom), 6'($urandom), 3'($urandom % 8),
                  1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule